// File: doc/BRIEF.md
# ADC Window Compare Detector

This block watches the stream of finished analog-to-digital conversion results and tests each one against two programmable 16-bit limits. The first limit, the below reference, is a value that the result must be under. The second, the above reference, is a value that the result must exceed. When a conversion-complete strobe arrives and the result meets the window condition, a sticky window flag is raised. The flag stays high until software pulses a clear input.

The two limits serve both detection styles. If the below reference is larger than the above reference, the window is the band between them, and the flag reports results inside that band. If the above reference is larger, the flag reports results that fall outside the band. Every comparison is strict, so a result equal to a limit never counts. When the two limits are equal, the flag cannot be set.

Both limits are loaded one byte at a time through a small byte-wide register port, and the same port reads them back. The comparison is a plain unsigned magnitude compare over the whole 16-bit word. It therefore works the same way for right-justified 10-bit results, left-justified 10-bit results and 8-bit results, as long as software writes the limits in the same format as the results.

Top module: `adc_window_det`

## Requirements
- R1: After reset, all four threshold bytes read back as 0x00 and `win_flag` is 0.
- R2: Register address map: 0 is the above-reference low byte, 1 is the above-reference high byte, 2 is the below-reference low byte and 3 is the below-reference high byte. A write with `reg_wr_en` takes effect at the next clock edge. `reg_rdata` shows the stored byte at `reg_addr` combinationally.
- R3: When below > above, a strobed result sets the flag only if above < result < below, with both ends strict.
- R4: When above > below, a strobed result sets the flag if result < below or result > above, with both ends strict.
- R5: When above == below, no result sets the flag.
- R6: A result is evaluated only in a cycle where `conv_valid` is 1. A hit becomes visible on `win_flag` after the clock edge that ends the strobe cycle. A `conv_word` presented without the strobe has no effect.
- R7: `win_flag` stays set until `flag_clr` is asserted, and it drops after that edge. If a hit strobe and `flag_clr` arrive in the same cycle, the flag is set.
- R8: A strobe in the same cycle as a threshold write is compared against the thresholds held before that write.
- R9: The comparison is an unsigned compare over the full 16-bit words. Left-justified limits (value shifted left by 6) and 8-bit limits (high byte only, low bytes 0x00) behave exactly like right-justified ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Threshold byte write enable |
| reg_addr | input | 2 | Threshold byte select (map in R2) |
| reg_wdata | input | 8 | Byte to write |
| reg_rdata | output | 8 | Stored byte at `reg_addr` |
| conv_valid | input | 1 | Conversion-complete strobe |
| conv_word | input | 16 | Conversion result |
| flag_clr | input | 1 | Clears the window flag |
| win_flag | output | 1 | Sticky window flag |

## Verification
The assertions assume that the design's own reset state is in place on every input edge after reset, and that `flag_clr` is the only way software lowers the flag. The clear property therefore applies only to cycles with no strobe, because under R7 a hit in the same cycle wins. The bench drives every input on the falling clock edge and holds strobe and clear for exactly one cycle. It reloads the limits only through the byte port. Because the flag is sticky, the bench clears it before each evaluated result, so each check sees a fresh outcome.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

    // Which detection the current limit ordering selects
    typedef enum logic [1:0] {
        WIN_NONE    = 2'd0,
        WIN_INSIDE  = 2'd1,
        WIN_OUTSIDE = 2'd2
    } win_mode_e;

endpackage

// File: rtl/adc_win_regs.sv
module adc_win_regs #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DATA_W-1:0] above,
    output logic [DATA_W-1:0] below
);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] below;
        logic [NBYTES-1:0][BYTE_W-1:0] above;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (addr == ADDR_W'(b))
                    bank_d.above[b] = wdata;
                if (addr == ADDR_W'(NBYTES + b))
                    bank_d.below[b] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank_q <= '0;
        else
            bank_q <= bank_d;
    end

    // Flat byte view for readback: above bytes first, then below bytes
    logic [2*NBYTES-1:0][BYTE_W-1:0] lanes;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g]          = bank_q.above[g];
        assign lanes[NBYTES + g] = bank_q.below[g];
    end

    assign rdata = lanes[addr];
    assign above = bank_q.above;
    assign below = bank_q.below;

endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
    import adc_win_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] above,
    input  logic [DATA_W-1:0] below,
    output logic              hit
);

    win_mode_e mode;
    logic      over_above;
    logic      under_below;

    always_comb begin
        if (below > above)
            mode = WIN_INSIDE;
        else if (above > below)
            mode = WIN_OUTSIDE;
        else
            mode = WIN_NONE;

        over_above  = word > above;
        under_below = word < below;

        unique case (mode)
            WIN_INSIDE:  hit = over_above && under_below;
            WIN_OUTSIDE: hit = over_above || under_below;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_window_det.sv
module adc_window_det #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTES = DATA_W / BYTE_W,
    localparam int ADDR_W = $clog2(2 * NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              flag_clr,
    output logic              win_flag
);

    typedef struct packed {
        logic flag;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [DATA_W-1:0] above_q;
    logic [DATA_W-1:0] below_q;
    logic              cmp_hit;

    adc_win_regs #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .above (above_q),
        .below (below_q)
    );

    // Uses the limits held before any write in this cycle
    adc_win_cmp #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .word  (conv_word),
        .above (above_q),
        .below (below_q),
        .hit   (cmp_hit)
    );

    always_comb begin
        st_d = st_q;
        if (flag_clr)
            st_d.flag = 1'b0;
        if (conv_valid && cmp_hit)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign win_flag = st_q.flag;

endmodule

// File: rtl/adc_window_det_chk.sv
module adc_window_det_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid,
    input logic [DATA_W-1:0] conv_word,
    input logic              flag_clr,
    input logic              win_flag,
    input logic [DATA_W-1:0] above,
    input logic [DATA_W-1:0] below
);

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_flag) |-> $past(conv_valid));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_flag && !flag_clr |=> win_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !conv_valid |=> !win_flag);

    // R3
    inside_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && (below > above) && (conv_word > above) && (conv_word < below)
        |=> win_flag);

    // R4
    outside_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && (above > below) && (conv_word < below) |=> win_flag);

    // R5
    equal_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && !win_flag && (above == below) |=> !win_flag);

    // R3
    inside_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && !win_flag && (below > above)
        && ((conv_word == above) || (conv_word == below)) |=> !win_flag);

endmodule

bind adc_window_det adc_window_det_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_word  (conv_word),
    .flag_clr   (flag_clr),
    .win_flag   (win_flag),
    .above      (above_q),
    .below      (below_q)
);

// File: tb/adc_window_det_test.sv
module adc_window_det_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_word = '0;
    logic        flag_clr = 1'b0;
    logic        win_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    adc_window_det uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .conv_valid (conv_valid),
        .conv_word  (conv_word),
        .flag_clr   (flag_clr),
        .win_flag   (win_flag)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    // Address map: 0 above lo, 1 above hi, 2 below lo, 3 below hi
    task automatic set_bounds(input logic [15:0] above, input logic [15:0] below);
        wr(2'd0, above[7:0]);
        wr(2'd1, above[15:8]);
        wr(2'd2, below[7:0]);
        wr(2'd3, below[15:8]);
    endtask

    task automatic clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Clear, strobe one result, then check the flag after the strobe edge
    task automatic conv_chk(input string tag, input logic [15:0] w, input logic exp);
        clr();
        conv_valid = 1'b1; conv_word = w;
        @(negedge clk);
        conv_valid = 1'b0;
        check(tag, {15'd0, win_flag}, {15'd0, exp});
    endtask

    task automatic t_reset();
        check("R1 flag", {15'd0, win_flag}, 16'd0);
        for (int a = 0; a < 4; a++) rd_chk("R1 byte", 2'(a), 8'h00);
    endtask

    task automatic t_regs();
        wr(2'd0, 8'h11);
        rd_chk("R2 above lo", 2'd0, 8'h11);
        wr(2'd1, 8'h22);
        wr(2'd2, 8'h33);
        wr(2'd3, 8'h44);
        rd_chk("R2 above lo kept", 2'd0, 8'h11);
        rd_chk("R2 above hi", 2'd1, 8'h22);
        rd_chk("R2 below lo", 2'd2, 8'h33);
        rd_chk("R2 below hi", 2'd3, 8'h44);
    endtask

    task automatic t_inside();
        set_bounds(16'h0040, 16'h0080);
        conv_chk("R3 mid", 16'h0060, 1'b1);
        conv_chk("R3 at above", 16'h0040, 1'b0);
        conv_chk("R3 at below", 16'h0080, 1'b0);
        conv_chk("R3 just in lo", 16'h0041, 1'b1);
        conv_chk("R3 just in hi", 16'h007F, 1'b1);
        conv_chk("R3 under", 16'h0010, 1'b0);
        conv_chk("R3 over", 16'h0300, 1'b0);
    endtask

    task automatic t_outside();
        set_bounds(16'h0080, 16'h0040);
        conv_chk("R4 low", 16'h0030, 1'b1);
        conv_chk("R4 high", 16'h0090, 1'b1);
        conv_chk("R4 middle", 16'h0060, 1'b0);
        conv_chk("R4 at below", 16'h0040, 1'b0);
        conv_chk("R4 at above", 16'h0080, 1'b0);
        conv_chk("R4 zero", 16'h0000, 1'b1);
    endtask

    task automatic t_equal();
        set_bounds(16'h0050, 16'h0050);
        conv_chk("R5 under", 16'h0010, 1'b0);
        conv_chk("R5 equal", 16'h0050, 1'b0);
        conv_chk("R5 over", 16'h0090, 1'b0);
    endtask

    task automatic t_strobe();
        set_bounds(16'h0040, 16'h0080);
        clr();
        conv_word = 16'h0060;
        repeat (3) @(negedge clk);
        check("R6 no strobe", {15'd0, win_flag}, 16'd0);
        conv_valid = 1'b1;
        #1;
        check("R6 not before edge", {15'd0, win_flag}, 16'd0);
        @(negedge clk);
        conv_valid = 1'b0;
        check("R6 after edge", {15'd0, win_flag}, 16'd1);
    endtask

    task automatic t_sticky();
        set_bounds(16'h0040, 16'h0080);
        conv_chk("R7 set", 16'h0060, 1'b1);
        conv_valid = 1'b1; conv_word = 16'h0010;
        @(negedge clk);
        conv_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 sticky", {15'd0, win_flag}, 16'd1);
        flag_clr = 1'b1; conv_valid = 1'b1; conv_word = 16'h0060;
        @(negedge clk);
        flag_clr = 1'b0; conv_valid = 1'b0;
        check("R7 set wins", {15'd0, win_flag}, 16'd1);
        flag_clr = 1'b1; conv_valid = 1'b1; conv_word = 16'h0010;
        @(negedge clk);
        flag_clr = 1'b0; conv_valid = 1'b0;
        check("R7 clear with miss", {15'd0, win_flag}, 16'd0);
    endtask

    task automatic t_same_cycle();
        set_bounds(16'h0040, 16'h0080);
        clr();
        reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h50;
        conv_valid = 1'b1; conv_word = 16'h0060;
        @(negedge clk);
        reg_wr_en = 1'b0; conv_valid = 1'b0;
        check("R8 old limits", {15'd0, win_flag}, 16'd1);
        conv_chk("R8 new limits", 16'h0060, 1'b0);
    endtask

    task automatic t_formats();
        set_bounds(16'h0040 << 6, 16'h0080 << 6);
        conv_chk("R9 left mid", 16'h0060 << 6, 1'b1);
        conv_chk("R9 left edge", 16'h0080 << 6, 1'b0);
        set_bounds(16'h4000, 16'h8000);
        conv_chk("R9 8bit mid", 16'h6000, 1'b1);
        conv_chk("R9 8bit edge", 16'h4000, 1'b0);
        conv_chk("R9 8bit above", 16'hC000, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_inside();
        t_outside();
        t_equal();
        t_strobe();
        t_sticky();
        t_same_cycle();
        t_formats();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule